// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block sits next to a small processor core and turns one hardware interrupt request into a complete entry sequence. The core marks the final cycle of each instruction with `instr_last`. If the request line is high in that cycle while interrupts are enabled, the block sets a pending flag. The core marks the first cycle of the next instruction with `instr_first`. If the flag is set in that cycle, the block begins an entry sequence. It stalls the core and raises the acknowledge line for one cycle. While acknowledge is high, it reads a 3-bit vector number from bits 4..2 of the data bus.

Next, the block saves the address of the preempted instruction as a 32-bit little-endian value. The save is four single-byte writes, one per clock, starting at byte address 8 × vector. It then loads the program counter with 8 × vector + 4, the word that follows the saved address. The enable flag clears itself when the sequence begins. Software sets it again through a dedicated input.

Top module: `intr_vec_seq`

## Requirements
- R1: A synchronous active-high reset clears `irq_ack`, `stall`, `mem_we`, `pc_load` and `ie`, and discards any pending request. After reset, an `instr_first` pulse does not start a sequence.
- R2: Pulsing `ie_set` makes `ie` read 1 on the next cycle. When a sequence begins, `ie` is cleared, and this clear overrides an `ie_set` pulse in the same cycle.
- R3: The request is sampled only in a cycle where `instr_last`=1, `ie`=1 and no sequence is running. A request that is high at any other time starts no sequence.
- R4: A clock edge with `instr_first`=1 and a pending request starts a sequence. From the next cycle, `irq_ack`=1 for exactly one cycle, with `stall`=1 and `ie`=0.
- R5: The vector is `data_bus[4:2]`, taken during the acknowledge cycle. All other data bus bits, and the bus value at any other time, have no effect.
- R6: The four cycles after acknowledge each carry one byte write (`mem_we`=1). The addresses are 8v, 8v+1, 8v+2 and 8v+3. The data is bytes 0..3 (least significant first) of the `pc_cur` value present at the starting edge.
- R7: The cycle after the last write has `pc_load`=1 for one cycle, with `pc_load_val` = 8v+4 and `mem_we`=0.
- R8: `stall` is 1 from the acknowledge cycle through the program counter load cycle (six cycles), and 0 in the cycle after.
- R9: Starting a sequence clears the pending flag. A later `instr_first` with no new sampled request starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Interrupt request line |
| instr_last | input | 1 | Core is in the final cycle of an instruction |
| instr_first | input | 1 | Core is in the first cycle of an instruction |
| irq_ack | output | 1 | Interrupt acknowledge, one cycle |
| data_bus | input | 8 | Data bus; bits 4..2 carry the vector |
| pc_cur | input | 32 | Address of the current instruction |
| pc_load | output | 1 | Load program counter strobe |
| pc_load_val | output | 32 | Handler entry address |
| ie_set | input | 1 | Software request to set the enable flag |
| ie | output | 1 | Interrupt enable flag |
| stall | output | 1 | Hold the core while the sequence runs |
| mem_we | output | 1 | Byte write strobe |
| mem_addr | output | 32 | Byte write address |
| mem_wdata | output | 8 | Byte write data |

## Verification
Some properties are checked on every cycle. Acknowledge lasts one cycle and always comes with stall high and the enable flag low. Writes follow acknowledge, and each write address is one above the previous one. The load value is one past the last write address. Stall falls only after a load.

Other behaviours depend on values chosen by the stimulus, so only the directed scenarios can show them. These are the vector decode from the bus bits, the little-endian byte order of the captured address, and the set/clear race on the enable flag. They also include requests that must be ignored (when disabled, off the instruction boundary, or after reset) and the clearing of the pending flag.

// File: rtl/intr_vec_pkg.sv
package intr_vec_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_SAVE = 2'd2,
    ST_JUMP = 2'd3
  } seq_state_t;
endpackage

// File: rtl/intr_pend_ctl.sv
// Holds the sampled-request flag and the enable flag; decides when a sequence starts.
module intr_pend_ctl (
  input  logic clk,
  input  logic rst,
  input  logic irq_req,
  input  logic instr_last,
  input  logic instr_first,
  input  logic ie_set,
  input  logic seq_idle,
  output logic start,
  output logic ie
);
  logic pend_q;
  logic ie_q;
  logic sample;

  assign sample = seq_idle & instr_last & irq_req & ie_q;
  assign start  = seq_idle & instr_first & pend_q;
  assign ie     = ie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (start) begin
      pend_q <= 1'b0;
    end else if (sample) begin
      pend_q <= 1'b1;
    end
  end

  // hardware clear on entry takes priority over the software set
  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q <= 1'b0;
    end else if (start) begin
      ie_q <= 1'b0;
    end else if (ie_set) begin
      ie_q <= 1'b1;
    end
  end
endmodule

// File: rtl/intr_seq_fsm.sv
// Sequence state, vector capture and return-address capture. Exposes next-state values.
module intr_seq_fsm
  import intr_vec_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int DATA_W  = 8,
  parameter int VEC_LSB = 2,
  parameter int VEC_W   = 3,
  parameter int NBYTES  = PC_W / 8,
  parameter int BIDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PC_W-1:0]   pc_cur,
  input  logic [DATA_W-1:0] data_bus,
  output logic              seq_idle,
  output seq_state_t        state_n,
  output logic [VEC_W-1:0]  vec_n,
  output logic [PC_W-1:0]   ret_n,
  output logic [BIDX_W-1:0] byte_n
);
  localparam logic [BIDX_W-1:0] LAST_BYTE = BIDX_W'(NBYTES - 1);

  seq_state_t        state_q;
  logic [VEC_W-1:0]  vec_q;
  logic [PC_W-1:0]   ret_q;
  logic [BIDX_W-1:0] byte_q;

  assign seq_idle = (state_q == ST_IDLE);

  always_comb begin
    state_n = state_q;
    vec_n   = vec_q;
    ret_n   = ret_q;
    byte_n  = byte_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_n = ST_ACK;
          ret_n   = pc_cur;
        end
      end
      ST_ACK: begin
        vec_n   = data_bus[VEC_LSB +: VEC_W];
        byte_n  = '0;
        state_n = ST_SAVE;
      end
      ST_SAVE: begin
        if (byte_q == LAST_BYTE) begin
          state_n = ST_JUMP;
        end else begin
          byte_n = byte_q + BIDX_W'(1);
        end
      end
      ST_JUMP: begin
        state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      vec_q   <= '0;
      ret_q   <= '0;
      byte_q  <= '0;
    end else begin
      state_q <= state_n;
      vec_q   <= vec_n;
      ret_q   <= ret_n;
      byte_q  <= byte_n;
    end
  end
endmodule

// File: rtl/intr_out_reg.sv
// Registers every output from the next-state values so outputs line up with the state.
module intr_out_reg
  import intr_vec_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int VEC_W      = 3,
  parameter int SLOT_SHIFT = 3,
  parameter int NBYTES     = PC_W / 8,
  parameter int BIDX_W     = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_t        state_n,
  input  logic [VEC_W-1:0]  vec_n,
  input  logic [PC_W-1:0]   ret_n,
  input  logic [BIDX_W-1:0] byte_n,
  output logic              irq_ack,
  output logic              stall,
  output logic              mem_we,
  output logic [PC_W-1:0]   mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_load_val
);
  localparam logic [PC_W-1:0] JUMP_OFS = PC_W'(NBYTES);

  logic [7:0]      ret_bytes [NBYTES];
  logic [PC_W-1:0] slot_base;
  logic [PC_W-1:0] byte_ofs;
  logic            save_n;

  genvar g;
  generate
    for (g = 0; g < NBYTES; g++) begin : g_split
      assign ret_bytes[g] = ret_n[g*8 +: 8];
    end
  endgenerate

  assign slot_base = {{(PC_W-VEC_W){1'b0}}, vec_n} << SLOT_SHIFT;
  assign byte_ofs  = {{(PC_W-BIDX_W){1'b0}}, byte_n};
  assign save_n    = (state_n == ST_SAVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_ack     <= 1'b0;
      stall       <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      pc_load     <= 1'b0;
      pc_load_val <= '0;
    end else begin
      irq_ack     <= (state_n == ST_ACK);
      stall       <= (state_n != ST_IDLE);
      mem_we      <= save_n;
      mem_addr    <= save_n ? (slot_base + byte_ofs) : '0;
      mem_wdata   <= save_n ? ret_bytes[byte_n] : 8'h00;
      pc_load     <= (state_n == ST_JUMP);
      pc_load_val <= (state_n == ST_JUMP) ? (slot_base + JUMP_OFS) : '0;
    end
  end
endmodule

// File: rtl/intr_vec_seq.sv
module intr_vec_seq
  import intr_vec_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int DATA_W     = 8,
  parameter int VEC_LSB    = 2,
  parameter int VEC_W      = 3,
  parameter int SLOT_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_req,
  input  logic              instr_last,
  input  logic              instr_first,
  output logic              irq_ack,
  input  logic [DATA_W-1:0] data_bus,
  input  logic [PC_W-1:0]   pc_cur,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_load_val,
  input  logic              ie_set,
  output logic              ie,
  output logic              stall,
  output logic              mem_we,
  output logic [PC_W-1:0]   mem_addr,
  output logic [7:0]        mem_wdata
);
  localparam int NBYTES = PC_W / 8;
  localparam int BIDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic              start;
  logic              seq_idle;
  seq_state_t        state_n;
  logic [VEC_W-1:0]  vec_n;
  logic [PC_W-1:0]   ret_n;
  logic [BIDX_W-1:0] byte_n;

  intr_pend_ctl u_pend (
    .clk        (clk),
    .rst        (rst),
    .irq_req    (irq_req),
    .instr_last (instr_last),
    .instr_first(instr_first),
    .ie_set     (ie_set),
    .seq_idle   (seq_idle),
    .start      (start),
    .ie         (ie)
  );

  intr_seq_fsm #(
    .PC_W   (PC_W),
    .DATA_W (DATA_W),
    .VEC_LSB(VEC_LSB),
    .VEC_W  (VEC_W),
    .NBYTES (NBYTES),
    .BIDX_W (BIDX_W)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .pc_cur  (pc_cur),
    .data_bus(data_bus),
    .seq_idle(seq_idle),
    .state_n (state_n),
    .vec_n   (vec_n),
    .ret_n   (ret_n),
    .byte_n  (byte_n)
  );

  intr_out_reg #(
    .PC_W      (PC_W),
    .VEC_W     (VEC_W),
    .SLOT_SHIFT(SLOT_SHIFT),
    .NBYTES    (NBYTES),
    .BIDX_W    (BIDX_W)
  ) u_out (
    .clk        (clk),
    .rst        (rst),
    .state_n    (state_n),
    .vec_n      (vec_n),
    .ret_n      (ret_n),
    .byte_n     (byte_n),
    .irq_ack    (irq_ack),
    .stall      (stall),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .pc_load    (pc_load),
    .pc_load_val(pc_load_val)
  );
endmodule

// File: rtl/intr_vec_seq_chk.sv
module intr_vec_seq_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            irq_ack,
  input logic            stall,
  input logic            ie,
  input logic            mem_we,
  input logic [PC_W-1:0] mem_addr,
  input logic            pc_load,
  input logic [PC_W-1:0] pc_load_val
);
  assert_ack_single_R4: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack);

  assert_ack_ctx_R4: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (stall && !ie));

  assert_ack_then_write_R6: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> mem_we);

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + PC_W'(1)));

  assert_write_stalled_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (stall && !irq_ack));

  assert_load_after_write_R7: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> ($past(mem_we) && !mem_we && (pc_load_val == $past(mem_addr) + PC_W'(1))));

  assert_load_releases_R8: assert property (@(posedge clk) disable iff (rst)
    pc_load |=> !stall);

  assert_stall_end_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(stall) |-> $past(pc_load));
endmodule

bind intr_vec_seq intr_vec_seq_chk #(.PC_W(PC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq_ack    (irq_ack),
  .stall      (stall),
  .ie         (ie),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .pc_load    (pc_load),
  .pc_load_val(pc_load_val)
);

// File: tb/intr_vec_seq_tb.sv
module intr_vec_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq_req = 1'b0;
  logic        instr_last = 1'b0;
  logic        instr_first = 1'b0;
  logic [7:0]  data_bus = 8'h00;
  logic [31:0] pc_cur = 32'h0;
  logic        ie_set = 1'b0;
  logic        irq_ack, pc_load, ie, stall, mem_we;
  logic [31:0] pc_load_val, mem_addr;
  logic [7:0]  mem_wdata;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  intr_vec_seq u_dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .instr_last(instr_last),
    .instr_first(instr_first), .irq_ack(irq_ack), .data_bus(data_bus),
    .pc_cur(pc_cur), .pc_load(pc_load), .pc_load_val(pc_load_val),
    .ie_set(ie_set), .ie(ie), .stall(stall), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_check(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      tick();
      check(irq_ack == 1'b0, req, "ack stays low", {31'b0, irq_ack}, 32'h0);
      check(stall == 1'b0, req, "stall stays low", {31'b0, stall}, 32'h0);
    end
  endtask

  task automatic enable_ie();
    ie_set = 1'b1;
    tick();
    ie_set = 1'b0;
    check(ie == 1'b1, "R2", "ie after set", {31'b0, ie}, 32'h1);
  endtask

  // full entry sequence; race drives ie_set at the starting edge
  task automatic t_service(input logic [31:0] pc, input logic [7:0] db,
                           input int v, input bit race);
    logic [31:0] base;
    base = 32'(v) * 8;
    enable_ie();
    instr_last = 1'b1; irq_req = 1'b1;
    tick();
    instr_last = 1'b0; irq_req = 1'b0;
    instr_first = 1'b1; pc_cur = pc; ie_set = race;
    tick();
    instr_first = 1'b0; ie_set = 1'b0; pc_cur = ~pc;
    check(irq_ack == 1'b1, "R4", "ack raised", {31'b0, irq_ack}, 32'h1);
    check(stall == 1'b1, "R8", "stall in ack", {31'b0, stall}, 32'h1);
    check(ie == 1'b0, race ? "R2" : "R4", "ie cleared at entry", {31'b0, ie}, 32'h0);
    data_bus = db;
    tick();
    data_bus = ~db;
    for (int i = 0; i < 4; i++) begin
      check(mem_we == 1'b1, "R6", "write strobe", {31'b0, mem_we}, 32'h1);
      check(irq_ack == 1'b0, "R4", "ack one cycle", {31'b0, irq_ack}, 32'h0);
      check(mem_addr == base + 32'(i), "R5", "write address", mem_addr, base + 32'(i));
      check(mem_wdata == pc[i*8 +: 8], "R6", "byte data", {24'b0, mem_wdata}, {24'b0, pc[i*8 +: 8]});
      tick();
    end
    check(pc_load == 1'b1, "R7", "pc load strobe", {31'b0, pc_load}, 32'h1);
    check(pc_load_val == base + 32'd4, "R7", "handler entry", pc_load_val, base + 32'd4);
    check(mem_we == 1'b0, "R7", "no write at jump", {31'b0, mem_we}, 32'h0);
    check(stall == 1'b1, "R8", "stall at jump", {31'b0, stall}, 32'h1);
    tick();
    check(stall == 1'b0, "R8", "stall released", {31'b0, stall}, 32'h0);
    check(pc_load == 1'b0, "R7", "load one cycle", {31'b0, pc_load}, 32'h0);
    check(ie == 1'b0, "R2", "ie still clear", {31'b0, ie}, 32'h0);
  endtask

  task automatic t_reset();
    check(irq_ack == 1'b0 && stall == 1'b0, "R1", "ack/stall after reset", {30'b0, irq_ack, stall}, 32'h0);
    check(mem_we == 1'b0 && pc_load == 1'b0, "R1", "we/load after reset", {30'b0, mem_we, pc_load}, 32'h0);
    check(ie == 1'b0, "R1", "ie after reset", {31'b0, ie}, 32'h0);
  endtask

  task automatic t_reset_drops_pending();
    enable_ie();
    instr_last = 1'b1; irq_req = 1'b1;
    tick();
    instr_last = 1'b0; irq_req = 1'b0;
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check(ie == 1'b0, "R1", "ie cleared by reset", {31'b0, ie}, 32'h0);
    enable_ie();
    instr_first = 1'b1;
    tick();
    instr_first = 1'b0;
    check(irq_ack == 1'b0, "R1", "pending dropped by reset", {31'b0, irq_ack}, 32'h0);
    idle_check("R1", 2);
    rst = 1'b1; tick(); rst = 1'b0;
  endtask

  task automatic t_disabled_ignored();
    instr_last = 1'b1; irq_req = 1'b1;
    tick();
    instr_last = 1'b0; irq_req = 1'b0;
    instr_first = 1'b1;
    tick();
    instr_first = 1'b0;
    check(irq_ack == 1'b0, "R3", "request ignored while disabled", {31'b0, irq_ack}, 32'h0);
    idle_check("R3", 2);
  endtask

  task automatic t_off_boundary();
    enable_ie();
    irq_req = 1'b1;
    tick(); tick(); tick();
    irq_req = 1'b0;
    instr_first = 1'b1;
    tick();
    instr_first = 1'b0;
    check(irq_ack == 1'b0, "R3", "request off boundary ignored", {31'b0, irq_ack}, 32'h0);
    idle_check("R3", 2);
    rst = 1'b1; tick(); rst = 1'b0;
  endtask

  task automatic t_race_then_masked();
    t_service(32'h0000_1234, 8'b0000_1000, 2, 1'b1);
    instr_last = 1'b1; irq_req = 1'b1;
    tick();
    instr_last = 1'b0; irq_req = 1'b0;
    instr_first = 1'b1;
    tick();
    instr_first = 1'b0;
    check(irq_ack == 1'b0, "R2", "set lost the race, request masked", {31'b0, irq_ack}, 32'h0);
    idle_check("R2", 1);
  endtask

  task automatic t_pending_cleared();
    t_service(32'h8000_0010, 8'b1110_0101, 1, 1'b0);
    enable_ie();
    instr_first = 1'b1;
    tick();
    instr_first = 1'b0;
    check(irq_ack == 1'b0, "R9", "no re-entry without new request", {31'b0, irq_ack}, 32'h0);
    idle_check("R9", 2);
    rst = 1'b1; tick(); rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    t_reset();
    t_reset_drops_pending();
    t_disabled_ignored();
    t_off_boundary();
    t_service(32'hA1B2_C3D4, 8'b1111_0111, 5, 1'b0);
    t_service(32'h0102_0304, 8'b0000_0011, 0, 1'b0);
    t_service(32'hDEAD_BEEF, 8'b0001_1100, 7, 1'b0);
    t_race_then_masked();
    t_pending_cleared();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule